// File: doc/BRIEF.md
# Indirect Palette Register Access Port

This block is the host-facing register interface of a video palette. A small synchronous bus reaches four word locations. One holds an index pointer. One is a data window into a 256-entry color table whose entries each carry red, green and blue at 10 bits per component. One is a data window into a small bank of control, mask, identification and test registers. The fourth is a directly addressed mode register.

A host first loads the pointer, then streams accesses through a data window. Each color-table entry is transferred as a short sequence of component accesses: three in 8-bit resolution and six in 10-bit resolution. The pointer advances on its own once the whole red/green/blue sequence is done, so a run of entries needs only one pointer write. Writes are staged until the sequence ends, and the complete 30-bit entry is then committed in one cycle. The control-register values and the mode register are exported as outputs for the pixel path.

Top module: `pal_regport_top`

## Requirements
- R1: After reset, the pointer, the mode register, both command registers and both test registers are zero, the pixel mask is 0xFF and `rdata_o` is zero.
- R2: Word address 0 is the pointer, 1 the color window, 2 the control window and 3 the mode register. The pointer and the mode register read back what was written. Mode bit 1 selects the resolution: 0 gives 8-bit and 1 gives 10-bit. `mode_o` shows the mode register.
- R3: In 8-bit resolution, three color-window writes fill red, green and blue of the pointed entry, each stored as the data byte followed by two zero bits. The pointer increments after the third write.
- R4: In 8-bit resolution, three color-window reads return the upper 8 bits of red, green and blue in that order. The pointer increments after the third read.
- R5: In 10-bit resolution, six accesses run in this order: red upper 8, red lower 2, green upper 8, green lower 2, blue upper 8, blue lower 2. Lower parts travel on data bits 1:0, and lower-part reads return zero in bits 7:2. The pointer increments after the sixth access.
- R6: A pointer write restarts the component sequence at the red (first) access.
- R7: The pointer wraps from 0xFF to 0x00 when it auto-increments.
- R8: A color entry in the table is unchanged until the final component write of its sequence. An abandoned partial sequence leaves it intact.
- R9: Control indices: 0x00 returns `pix_test_i` and is read only; 0x01 is the DAC test byte; 0x02 is the sync/blank test register, 3 bits wide, with reads zero-extended; 0x03 always reads 0x8C; 0x04 is the pixel mask; 0x06 and 0x07 are command registers 2 and 3. Each writable register appears on its output.
- R10: Control-window writes to read-only or unused indices change nothing. Reads of unused indices (0x05 and 0x08 to 0xFF) return zero. Control-window accesses never move the pointer.
- R11: Read data appears on `rdata_o` in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Word address of the access |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| pix_test_i | input | 8 | Pixel test value captured by the pixel path |
| mode_o | output | 8 | Mode register |
| pix_mask_o | output | 8 | Pixel mask |
| cmd2_o | output | 8 | Command register 2 |
| cmd3_o | output | 8 | Command register 3 |
| dac_test_o | output | 8 | DAC test register |
| sync_test_o | output | 3 | Sync/blank test register |

## Verification
The assertions assume that the host never raises the write and read strobes in the same cycle. They also assume that the resolution bit does not change while a color sequence is partly done. Within those limits, they check the pointer and phase counter and the commit-only-at-end rule for the table. The stimulus issues one strobe at a time, with an idle cycle after each access. It changes the mode only after a pointer write, because that write has already reset the sequence.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    OFS_PTR   = 2'd0,
    OFS_COLOR = 2'd1,
    OFS_CTRL  = 2'd2,
    OFS_MODE  = 2'd3
  } ofs_e;

  localparam int unsigned MODE_RES_BIT = 1;

  localparam logic [7:0] IDX_PIX_TEST = 8'h00;
  localparam logic [7:0] IDX_DAC_TEST = 8'h01;
  localparam logic [7:0] IDX_SYNC_TST = 8'h02;
  localparam logic [7:0] IDX_ID       = 8'h03;
  localparam logic [7:0] IDX_MASK     = 8'h04;
  localparam logic [7:0] IDX_CMD2     = 8'h06;
  localparam logic [7:0] IDX_CMD3     = 8'h07;
endpackage

// File: rtl/pal_seq.sv
module pal_seq #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ptr_we_i,
  input  logic [IDX_W-1:0] ptr_wdata_i,
  input  logic             col_acc_i,
  input  logic             ten_bit_i,
  output logic [IDX_W-1:0] ptr_o,
  output logic [2:0]       phase_o,
  output logic             last_o
);
  logic [IDX_W-1:0] ptr_q;
  logic [2:0]       phase_q;

  // 8-bit: phases 0..2; 10-bit: phases 0..5
  assign last_o = ten_bit_i ? (phase_q == 3'd5) : (phase_q >= 3'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      phase_q <= '0;
    end else if (ptr_we_i) begin
      ptr_q   <= ptr_wdata_i;
      phase_q <= '0;
    end else if (col_acc_i) begin
      if (last_o) begin
        phase_q <= '0;
        ptr_q   <= ptr_q + 1'b1;
      end else begin
        phase_q <= phase_q + 3'd1;
      end
    end
  end

  assign ptr_o   = ptr_q;
  assign phase_o = phase_q;

  // R5
  phase_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q <= 3'd5);

  // R6
  ptr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_we_i |=> (phase_q == 3'd0) && (ptr_q == $past(ptr_wdata_i)));

  // R7
  ptr_incr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_acc_i && last_o && !ptr_we_i) |=> ptr_q == IDX_W'($past(ptr_q) + 1'b1));

  // R3
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_acc_i && !last_o && !ptr_we_i) |=> $stable(ptr_q));
endmodule

// File: rtl/pal_color_mem.sv
module pal_color_mem #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 10,
  parameter int unsigned BUS_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [2:0]       phase_i,
  input  logic             ten_bit_i,
  input  logic             last_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rd_byte_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam int unsigned LO_W  = COMP_W - BUS_W;
  localparam int unsigned ENT_W = 3 * COMP_W;

  logic [ENT_W-1:0]  mem [DEPTH];
  logic [COMP_W-1:0] stg [3];
  logic [1:0]        comp;
  logic              lo_acc;
  logic [COMP_W-1:0] blue_fin;
  logic [ENT_W-1:0]  entry;
  logic [COMP_W-1:0] comp_val;

  always_comb begin
    comp = ten_bit_i ? phase_i[2:1] : phase_i[1:0];
    if (comp == 2'd3) comp = 2'd2;
    lo_acc = ten_bit_i & phase_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 3; i++) stg[i] <= '0;
    end else if (we_i) begin
      if (!ten_bit_i)
        stg[comp] <= {wdata_i, {LO_W{1'b0}}};
      else if (lo_acc)
        stg[comp][LO_W-1:0] <= wdata_i[LO_W-1:0];
      else
        stg[comp][COMP_W-1 -: BUS_W] <= wdata_i;
    end
  end

  assign blue_fin = ten_bit_i ? {stg[2][COMP_W-1 -: BUS_W], wdata_i[LO_W-1:0]}
                              : {wdata_i, {LO_W{1'b0}}};

  // entry commits only on the final component write
  always_ff @(posedge clk_i) begin
    if (we_i && last_i) mem[idx_i] <= {stg[0], stg[1], blue_fin};
  end

  assign entry = mem[idx_i];

  always_comb begin
    case (comp)
      2'd0:    comp_val = entry[3*COMP_W-1 -: COMP_W];
      2'd1:    comp_val = entry[2*COMP_W-1 -: COMP_W];
      default: comp_val = entry[COMP_W-1 -: COMP_W];
    endcase
    if (lo_acc) rd_byte_o = {{(BUS_W-LO_W){1'b0}}, comp_val[LO_W-1:0]};
    else        rd_byte_o = comp_val[COMP_W-1 -: BUS_W];
  end

  // R8
  staged_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !last_i) |=> mem[$past(idx_i)] === $past(mem[idx_i]));
endmodule

// File: rtl/pal_ctrl_bank.sv
module pal_ctrl_bank #(
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned BUS_W    = 8,
  parameter int unsigned SYNC_W   = 3,
  parameter logic [7:0]  ID_VALUE = 8'h8C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [BUS_W-1:0]  pix_test_i,
  output logic [BUS_W-1:0]  rd_o,
  output logic [BUS_W-1:0]  dac_test_o,
  output logic [SYNC_W-1:0] sync_test_o,
  output logic [BUS_W-1:0]  pix_mask_o,
  output logic [BUS_W-1:0]  cmd2_o,
  output logic [BUS_W-1:0]  cmd3_o
);
  import pal_pkg::*;

  logic [7:0] idx8;
  logic       hi_idx;
  logic       writable;

  assign idx8   = 8'(idx_i);
  assign hi_idx = (IDX_W > 8) ? (idx_i >> 8) != '0 : 1'b0;
  assign writable = !hi_idx && (idx8 == IDX_DAC_TEST || idx8 == IDX_SYNC_TST ||
                    idx8 == IDX_MASK || idx8 == IDX_CMD2 || idx8 == IDX_CMD3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_test_o  <= '0;
      sync_test_o <= '0;
      pix_mask_o  <= '1;
      cmd2_o      <= '0;
      cmd3_o      <= '0;
    end else if (we_i && !hi_idx) begin
      case (idx8)
        IDX_DAC_TEST: dac_test_o  <= wdata_i;
        IDX_SYNC_TST: sync_test_o <= wdata_i[SYNC_W-1:0];
        IDX_MASK:     pix_mask_o  <= wdata_i;
        IDX_CMD2:     cmd2_o      <= wdata_i;
        IDX_CMD3:     cmd3_o      <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_o = '0;
    if (!hi_idx) begin
      case (idx8)
        IDX_PIX_TEST: rd_o = pix_test_i;
        IDX_DAC_TEST: rd_o = dac_test_o;
        IDX_SYNC_TST: rd_o = BUS_W'(sync_test_o);
        IDX_ID:       rd_o = BUS_W'(ID_VALUE);
        IDX_MASK:     rd_o = pix_mask_o;
        IDX_CMD2:     rd_o = cmd2_o;
        IDX_CMD3:     rd_o = cmd3_o;
        default:      rd_o = '0;
      endcase
    end
  end

  // R10
  ignored_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !writable) |=> $stable(dac_test_o) && $stable(sync_test_o) &&
      $stable(pix_mask_o) && $stable(cmd2_o) && $stable(cmd3_o));
endmodule

// File: rtl/pal_regport_top.sv
module pal_regport_top #(
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned COMP_W   = 10,
  parameter int unsigned BUS_W    = 8,
  parameter int unsigned SYNC_W   = 3,
  parameter logic [7:0]  ID_VALUE = 8'h8C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [BUS_W-1:0]  pix_test_i,
  output logic [BUS_W-1:0]  mode_o,
  output logic [BUS_W-1:0]  pix_mask_o,
  output logic [BUS_W-1:0]  cmd2_o,
  output logic [BUS_W-1:0]  cmd3_o,
  output logic [BUS_W-1:0]  dac_test_o,
  output logic [SYNC_W-1:0] sync_test_o
);
  import pal_pkg::*;

  ofs_e             ofs;
  logic             ptr_we, col_acc, col_we, ctrl_we, mode_we;
  logic [IDX_W-1:0] ptr;
  logic [2:0]       phase;
  logic             last, ten_bit;
  logic [BUS_W-1:0] col_rd, ctrl_rd, rd_mux, mode_q;

  assign ofs     = ofs_e'(addr_i);
  assign ptr_we  = we_i && ofs == OFS_PTR;
  assign col_acc = (we_i || re_i) && ofs == OFS_COLOR;
  assign col_we  = we_i && ofs == OFS_COLOR;
  assign ctrl_we = we_i && ofs == OFS_CTRL;
  assign mode_we = we_i && ofs == OFS_MODE;
  assign ten_bit = mode_q[MODE_RES_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= '0;
    else if (mode_we) mode_q <= wdata_i;
  end
  assign mode_o = mode_q;

  pal_seq #(.IDX_W(IDX_W)) u_seq (
    .clk_i, .rst_ni,
    .ptr_we_i(ptr_we), .ptr_wdata_i(IDX_W'(wdata_i)),
    .col_acc_i(col_acc), .ten_bit_i(ten_bit),
    .ptr_o(ptr), .phase_o(phase), .last_o(last)
  );

  pal_color_mem #(.IDX_W(IDX_W), .COMP_W(COMP_W), .BUS_W(BUS_W)) u_mem (
    .clk_i, .rst_ni,
    .we_i(col_we), .idx_i(ptr), .phase_i(phase), .ten_bit_i(ten_bit),
    .last_i(last), .wdata_i(wdata_i), .rd_byte_o(col_rd)
  );

  pal_ctrl_bank #(.IDX_W(IDX_W), .BUS_W(BUS_W), .SYNC_W(SYNC_W), .ID_VALUE(ID_VALUE)) u_ctrl (
    .clk_i, .rst_ni,
    .we_i(ctrl_we), .idx_i(ptr), .wdata_i(wdata_i), .pix_test_i(pix_test_i),
    .rd_o(ctrl_rd), .dac_test_o(dac_test_o), .sync_test_o(sync_test_o),
    .pix_mask_o(pix_mask_o), .cmd2_o(cmd2_o), .cmd3_o(cmd3_o)
  );

  always_comb begin
    case (ofs)
      OFS_PTR:   rd_mux = BUS_W'(ptr);
      OFS_COLOR: rd_mux = col_rd;
      OFS_CTRL:  rd_mux = ctrl_rd;
      default:   rd_mux = mode_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_mux;
  end

  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && re_i));

  // R11
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

  // R9
  id_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && ofs == OFS_CTRL && ptr == IDX_W'(IDX_ID)) |=> rdata_o == BUS_W'(ID_VALUE));

  // R2
  mode_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we |=> mode_o == $past(wdata_i));

  // R10
  ctrl_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((we_i || re_i) && ofs == OFS_CTRL) |=> $stable(ptr));
endmodule

// File: tb/sim_pal_regport_top.sv
module sim_pal_regport_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0, re = 1'b0;
  logic [7:0] rdata, pix_test = 8'h5A;
  logic [7:0] mode, mask, cmd2, cmd3, dac_t;
  logic [2:0] sync_t;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       re_q = 1'b0;

  always #2 clk = ~clk;

  pal_regport_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .pix_test_i(pix_test),
    .mode_o(mode), .pix_mask_o(mask), .cmd2_o(cmd2), .cmd3_o(cmd3),
    .dac_test_o(dac_t), .sync_test_o(sync_t)
  );

  localparam logic [1:0] A_PTR = 2'd0, A_COL = 2'd1, A_CTL = 2'd2, A_MODE = 2'd3;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; re = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); re = 1'b0;
  endtask

  // monitor: data is valid one edge after the strobe
  always @(posedge clk) re_q <= re;
  always @(negedge clk) begin
    if (re_q) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected read actual=%h expected=none", rdata);
      end else begin
        chk(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdata, 8'h00, "R1 rdata");
    chk(mode, 8'h00, "R1 mode");
    chk(mask, 8'hFF, "R1 mask");
    chk(cmd2, 8'h00, "R1 cmd2");
    chk({5'd0, sync_t}, 8'h00, "R1 sync");
    rd(A_PTR, 8'h00, "R1 ptr");

    // R2 map and readback
    wr(A_PTR, 8'h10);  rd(A_PTR, 8'h10, "R2 ptr");
    wr(A_MODE, 8'hC4); rd(A_MODE, 8'hC4, "R2 mode");
    chk(mode, 8'hC4, "R2 mode_o");
    wr(A_MODE, 8'h00);

    // R3 8-bit write
    wr(A_PTR, 8'h10);
    wr(A_COL, 8'hAA); rd(A_PTR, 8'h10, "R3 ptr held");
    wr(A_COL, 8'h55); wr(A_COL, 8'h0F);
    rd(A_PTR, 8'h11, "R3 ptr inc");
    // R4 8-bit read
    wr(A_PTR, 8'h10);
    rd(A_COL, 8'hAA, "R4 red"); rd(A_COL, 8'h55, "R4 green"); rd(A_COL, 8'h0F, "R4 blue");
    rd(A_PTR, 8'h11, "R4 ptr inc");

    // R5 10-bit
    wr(A_MODE, 8'h02);
    wr(A_PTR, 8'h20);
    wr(A_COL, 8'h81); wr(A_COL, 8'h03); wr(A_COL, 8'h42);
    wr(A_COL, 8'hFE); wr(A_COL, 8'hC3); wr(A_COL, 8'h01);
    rd(A_PTR, 8'h21, "R5 ptr inc");
    wr(A_PTR, 8'h20);
    rd(A_COL, 8'h81, "R5 r hi"); rd(A_COL, 8'h03, "R5 r lo");
    rd(A_COL, 8'h42, "R5 g hi"); rd(A_COL, 8'h02, "R5 g lo");
    rd(A_COL, 8'hC3, "R5 b hi"); rd(A_COL, 8'h01, "R5 b lo");
    rd(A_PTR, 8'h21, "R5 ptr after reads");
    // R3 low bits zero from 8-bit write
    wr(A_PTR, 8'h10);
    rd(A_COL, 8'hAA, "R3 r hi"); rd(A_COL, 8'h00, "R3 r lo zero");
    rd(A_COL, 8'h55, "R3 g hi"); rd(A_COL, 8'h00, "R3 g lo zero");
    rd(A_COL, 8'h0F, "R3 b hi"); rd(A_COL, 8'h00, "R3 b lo zero");
    // R4 8-bit read of 10-bit entry
    wr(A_MODE, 8'h00);
    wr(A_PTR, 8'h20);
    rd(A_COL, 8'h81, "R4 upper r"); rd(A_COL, 8'h42, "R4 upper g"); rd(A_COL, 8'hC3, "R4 upper b");

    // R6 pointer write restarts phase
    wr(A_PTR, 8'h30); wr(A_COL, 8'h11);
    wr(A_PTR, 8'h30);
    wr(A_COL, 8'h77); wr(A_COL, 8'h88); wr(A_COL, 8'h99);
    wr(A_PTR, 8'h30);
    rd(A_COL, 8'h77, "R6 red"); rd(A_COL, 8'h88, "R6 green"); rd(A_COL, 8'h99, "R6 blue");

    // R8 abandoned partial write
    wr(A_PTR, 8'h10); wr(A_COL, 8'h01); wr(A_COL, 8'h02);
    wr(A_PTR, 8'h10);
    rd(A_COL, 8'hAA, "R8 red kept"); rd(A_COL, 8'h55, "R8 green kept"); rd(A_COL, 8'h0F, "R8 blue kept");

    // R7 wrap
    wr(A_PTR, 8'hFF);
    wr(A_COL, 8'h12); wr(A_COL, 8'h34); wr(A_COL, 8'h56);
    rd(A_PTR, 8'h00, "R7 wrap");
    wr(A_PTR, 8'hFF);
    rd(A_COL, 8'h12, "R7 r"); rd(A_COL, 8'h34, "R7 g"); rd(A_COL, 8'h56, "R7 b");
    rd(A_PTR, 8'h00, "R7 wrap read");

    // R9 control bank
    wr(A_PTR, 8'h03); rd(A_CTL, 8'h8C, "R9 id");
    wr(A_PTR, 8'h00); rd(A_CTL, 8'h5A, "R9 pix test");
    wr(A_PTR, 8'h04); wr(A_CTL, 8'h0F); rd(A_CTL, 8'h0F, "R9 mask");
    chk(mask, 8'h0F, "R9 mask_o");
    wr(A_PTR, 8'h06); wr(A_CTL, 8'h3C); rd(A_CTL, 8'h3C, "R9 cmd2");
    chk(cmd2, 8'h3C, "R9 cmd2_o");
    wr(A_PTR, 8'h07); wr(A_CTL, 8'hC5); rd(A_CTL, 8'hC5, "R9 cmd3");
    chk(cmd3, 8'hC5, "R9 cmd3_o");
    wr(A_PTR, 8'h01); wr(A_CTL, 8'h12); rd(A_CTL, 8'h12, "R9 dac");
    chk(dac_t, 8'h12, "R9 dac_o");
    wr(A_PTR, 8'h02); wr(A_CTL, 8'hFF); rd(A_CTL, 8'h07, "R9 sync width");
    chk({5'd0, sync_t}, 8'h07, "R9 sync_o");

    // R10 ignored writes, zero reads, pointer fixed
    wr(A_PTR, 8'h03); wr(A_CTL, 8'h00); rd(A_CTL, 8'h8C, "R10 id write ignored");
    rd(A_PTR, 8'h03, "R10 ptr fixed");
    wr(A_PTR, 8'h05); wr(A_CTL, 8'hFF); rd(A_CTL, 8'h00, "R10 idx5 zero");
    wr(A_PTR, 8'h40); wr(A_CTL, 8'hEE); rd(A_CTL, 8'h00, "R10 idx40 zero");
    wr(A_PTR, 8'h00); wr(A_CTL, 8'h99); rd(A_CTL, 8'h5A, "R10 pix test ro");
    chk(mask, 8'h0F, "R10 mask kept"); chk(cmd2, 8'h3C, "R10 cmd2 kept");
    chk(cmd3, 8'hC5, "R10 cmd3 kept"); chk(dac_t, 8'h12, "R10 dac kept");

    // R11 hold
    rd(A_MODE, 8'h00, "R11 read");
    wr(A_MODE, 8'hA5);
    repeat (3) @(negedge clk);
    chk(rdata, 8'h00, "R11 hold");
    rd(A_MODE, 8'hA5, "R11 new read");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R11 pending reads actual=%0d expected=0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule